// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small field-configurable logic fabric of the PAL kind. A programmable AND plane forms product terms from any mix of true and complemented literals. Each product term is built from the external inputs and from the state fed back by every output cell. A fixed OR gate per output cell sums its own group of product terms. The sum then passes through a per-cell stage that can register it, invert it and gate the output enable.

Configuration arrives one bit per clock on a serial port into a shadow register. It only reaches the logic when a separate load strobe copies the whole shadow into the active register, so the fabric never runs on a half-written pattern. All cell flip-flops share the system clock and a synchronous active-high reset. The value fed back into the AND plane is always the cell's flip-flop state. This keeps the fabric free of combinational loops whatever pattern is loaded.

Configuration layout: let S = N_IN + N_OUT be the number of array signals. Signal s < N_IN is `in_sig[s]`, and signal N_IN+m is the flip-flop state of cell m. A term field is 1+2S bits wide. Its bit 0 enables the term. Bit 1+2s selects the true literal of signal s and bit 2+2s selects the complemented literal. A cell field is 3 + TERMS·(1+2S) bits wide. Its bit 0 selects registered output, bit 1 inverts the output and bit 2 enables the output. Term t of the cell starts at bit 3 + t·(1+2S). Cell m occupies active bits starting at m times the cell width.

Top module: `pal_array`

## Requirements
- R1: While `cfg_shift_en` is high, each rising clock edge shifts the shadow register down by one position and places `cfg_bit` at its top index. A pattern is therefore sent with its bit 0 first and lands in order after exactly CFG_W shifts.
- R2: The active configuration changes only on a clock edge where `cfg_load` is high, and then takes the shadow value held before that edge. Shifting a new pattern without a load leaves `pad_out` and `pad_oe` behaving as under the old pattern.
- R3: Synchronous reset clears the shadow register, the active register and every cell flip-flop. After reset, `pad_oe` and `pad_out` are all 0.
- R4: An enabled product term is the AND of its selected literals. A signal with neither literal selected does not affect the term, so an enabled term with no literals selected is 1.
- R5: A product term whose enable bit is 0 is 0 and adds nothing to the sum, whatever literals it selects.
- R6: Each cell's sum is the OR of its own TERMS product terms only.
- R7: With the registered-select bit at 0, `pad_out[m]` equals the current sum XOR the invert bit, in the same cycle.
- R8: With the registered-select bit at 1, `pad_out[m]` equals the sum captured at the last rising edge XOR the invert bit. It does not follow the present sum between edges.
- R9: The flip-flop of every cell captures its sum on each rising edge in both modes. That state, taken before inversion, is array signal N_IN+m whether or not the output is enabled.
- R10: `pad_oe[m]` equals the enable bit of cell m. `pad_out[m]` still carries the cell value while the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the cells and the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift enable for the serial configuration port |
| cfg_bit | input | 1 | Serial configuration data bit |
| cfg_load | input | 1 | Copies the shadow register into the active configuration |
| in_sig | input | N_IN | External array inputs |
| pad_out | output | N_OUT | Cell output values after the mode and polarity stages |
| pad_oe | output | N_OUT | Per-cell output enable |

## Verification
The checker watches the configuration path on every cycle. It checks the serial shift and its bit order, the hold of both registers between strobes, the exact copy made by a load, and the cleared state after reset. The Boolean behaviour of the fabric can only be shown by the bench's scenarios. These cover sweeps of all input combinations through sums of products, disabled and empty terms, and inversion. A toggling registered cell driven through its own feedback shows registered timing and the feedback path. A pattern shifted without a load shows that the running logic is left alone.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Mode bits at the bottom of every cell field: bit0 registered, bit1 invert, bit2 enable
    typedef struct packed {
        logic oe;
        logic invert;
        logic reg_sel;
    } mc_mode_t;

    localparam int MODE_W = $bits(mc_mode_t);

    function automatic int term_width(input int nsig);
        return 1 + 2 * nsig;
    endfunction

    function automatic int cell_width(input int nsig, input int terms);
        return MODE_W + terms * term_width(nsig);
    endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         load,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (shift_en) shadow <= {bit_in, shadow[W-1:1]};
            if (load)     active <= shadow;
        end
    end
endmodule

// File: rtl/pal_product_term.sv
module pal_product_term
    import pal_pkg::*;
#(
    parameter int NSIG = 8,
    localparam int TW  = term_width(NSIG)
) (
    input  logic [NSIG-1:0] sig,
    input  logic [TW-1:0]   cfg,
    output logic            prod
);
    always_comb begin
        prod = cfg[0];
        for (int s = 0; s < NSIG; s++) begin
            if (cfg[1 + 2*s] && !sig[s]) prod = 1'b0;
            if (cfg[2 + 2*s] &&  sig[s]) prod = 1'b0;
        end
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int NSIG  = 8,
    parameter int TERMS = 4,
    localparam int TW   = term_width(NSIG),
    localparam int CW   = cell_width(NSIG, TERMS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] sig,
    input  logic [CW-1:0]   cfg,
    output logic            out,
    output logic            oe,
    output logic            q
);
    mc_mode_t         mode;
    logic [TERMS-1:0] prods;
    logic             sum;

    assign mode = mc_mode_t'(cfg[MODE_W-1:0]);

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        pal_product_term #(.NSIG(NSIG)) u_term (
            .sig  (sig),
            .cfg  (cfg[MODE_W + t*TW +: TW]),
            .prod (prods[t])
        );
    end

    assign sum = |prods;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= sum;
    end

    assign out = (mode.reg_sel ? q : sum) ^ mode.invert;
    assign oe  = mode.oe;
endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int TERMS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift_en,
    input  logic             cfg_bit,
    input  logic             cfg_load,
    input  logic [N_IN-1:0]  in_sig,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);
    localparam int NSIG  = N_IN + N_OUT;
    localparam int CW    = cell_width(NSIG, TERMS);
    localparam int CFG_W = N_OUT * CW;

    logic [CFG_W-1:0] cfg_shadow;
    logic [CFG_W-1:0] cfg_active;
    logic [N_OUT-1:0] fb_q;
    logic [NSIG-1:0]  sig;

    pal_cfg_chain #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_shift_en),
        .bit_in   (cfg_bit),
        .load     (cfg_load),
        .shadow   (cfg_shadow),
        .active   (cfg_active)
    );

    assign sig = {fb_q, in_sig};

    for (genvar m = 0; m < N_OUT; m++) begin : g_cell
        pal_macrocell #(.NSIG(NSIG), .TERMS(TERMS)) u_cell (
            .clk (clk),
            .rst (rst),
            .sig (sig),
            .cfg (cfg_active[m*CW +: CW]),
            .out (pad_out[m]),
            .oe  (pad_oe[m]),
            .q   (fb_q[m])
        );
    end
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int W     = 64,
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_shift_en,
    input logic             cfg_bit,
    input logic             cfg_load,
    input logic [W-1:0]     cfg_shadow,
    input logic [W-1:0]     cfg_active,
    input logic [N_OUT-1:0] fb_q
);
    // R1: new bit enters at the top
    assert_shift_top_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_shift_en |=> cfg_shadow[W-1] == $past(cfg_bit));

    // R1: older bits move one position down
    assert_shift_down_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_shift_en |=> cfg_shadow[W-2:0] == $past(cfg_shadow[W-1:1]));

    // R1: shadow holds when not shifting
    assert_shadow_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift_en |=> $stable(cfg_shadow));

    // R2: active changes only on a load
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_active));

    // R2: load copies the pre-edge shadow
    assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> cfg_active == $past(cfg_shadow));

    // R3: reset clears all state
    assert_reset_clear_R3: assert property (@(posedge clk)
        rst |=> (cfg_shadow == '0 && cfg_active == '0 && fb_q == '0));
endmodule

bind pal_array pal_array_chk #(.W(CFG_W), .N_OUT(N_OUT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_shift_en (cfg_shift_en),
    .cfg_bit      (cfg_bit),
    .cfg_load     (cfg_load),
    .cfg_shadow   (cfg_shadow),
    .cfg_active   (cfg_active),
    .fb_q         (fb_q)
);

// File: tb/pal_array_test.sv
module pal_array_test;
    localparam int N_IN  = 4;
    localparam int N_OUT = 2;
    localparam int TERMS = 2;
    localparam int S     = N_IN + N_OUT;
    localparam int TW    = 1 + 2*S;
    localparam int CW    = 3 + TERMS*TW;
    localparam int W     = N_OUT*CW;

    logic clk = 0;
    logic rst = 1;
    logic cfg_shift_en = 0, cfg_bit = 0, cfg_load = 0;
    logic [N_IN-1:0]  in_sig = '0;
    logic [N_OUT-1:0] pad_out, pad_oe;

    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .TERMS(TERMS)) uut (
        .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
        .cfg_load(cfg_load), .in_sig(in_sig), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // configuration builders follow the layout stated in the brief
    function automatic int cbase(input int m); return m*CW; endfunction
    function automatic int tbase(input int m, input int t); return m*CW + 3 + t*TW; endfunction

    task automatic set_mode(inout logic [W-1:0] v, input int m, input bit rs, input bit inv, input bit oe);
        v[cbase(m)]   = rs;
        v[cbase(m)+1] = inv;
        v[cbase(m)+2] = oe;
    endtask

    task automatic set_term(inout logic [W-1:0] v, input int m, input int t, input bit on);
        v[tbase(m,t)] = on;
    endtask

    task automatic set_lit(inout logic [W-1:0] v, input int m, input int t, input int s, input bit comp);
        v[tbase(m,t) + 1 + 2*s + (comp ? 1 : 0)] = 1'b1;
    endtask

    task automatic shift_cfg(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            cfg_shift_en = 1; cfg_bit = v[i];
        end
        @(negedge clk);
        cfg_shift_en = 0; cfg_bit = 0;
    endtask

    task automatic load_cfg;
        @(negedge clk) cfg_load = 1;
        @(negedge clk) cfg_load = 0;
    endtask

    initial begin
        #300000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] cfg_a, cfg_b, cfg_c;
        logic q_exp;
        logic [7:0] pat;

        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R3 oe after reset", 8'(pad_oe), 8'h0);
        check("R3 out after reset", 8'(pad_out), 8'h0);

        // Config A: cell0 comb, in0&~in1 | in2&in3; cell1 comb inverted, in0 | (disabled term on in1)
        cfg_a = '0;
        set_mode(cfg_a, 0, 0, 0, 1);
        set_term(cfg_a, 0, 0, 1); set_lit(cfg_a, 0, 0, 0, 0); set_lit(cfg_a, 0, 0, 1, 1);
        set_term(cfg_a, 0, 1, 1); set_lit(cfg_a, 0, 1, 2, 0); set_lit(cfg_a, 0, 1, 3, 0);
        set_mode(cfg_a, 1, 0, 1, 1);
        set_term(cfg_a, 1, 0, 1); set_lit(cfg_a, 1, 0, 0, 0);
        set_term(cfg_a, 1, 1, 0); set_lit(cfg_a, 1, 1, 1, 0);
        shift_cfg(cfg_a);
        check("R2 no effect before load", 8'(pad_oe), 8'h0);
        load_cfg();
        #1;
        check("R10 oe config A", 8'(pad_oe), 8'h3);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk) in_sig = v[3:0];
            #1;
            check("R4 R6 R7 R1 sum of products",
                  8'(pad_out[0]), 8'((v[0] & ~v[1]) | (v[2] & v[3])));
            check("R5 R7 inverted, disabled term ignored", 8'(pad_out[1]), 8'(~v[0] & 1));
        end
        @(negedge clk) in_sig = '0;
        @(negedge clk);   // flip-flops now hold 0

        // Config B: cell0 registered toggle q <= in0 ^ q; cell1 comb ~fb0, output disabled
        cfg_b = '0;
        set_mode(cfg_b, 0, 1, 0, 1);
        set_term(cfg_b, 0, 0, 1); set_lit(cfg_b, 0, 0, 0, 0); set_lit(cfg_b, 0, 0, N_IN+0, 1);
        set_term(cfg_b, 0, 1, 1); set_lit(cfg_b, 0, 1, 0, 1); set_lit(cfg_b, 0, 1, N_IN+0, 0);
        set_mode(cfg_b, 1, 0, 1, 0);
        set_term(cfg_b, 1, 0, 1); set_lit(cfg_b, 1, 0, N_IN+0, 0);
        shift_cfg(cfg_b);
        load_cfg();
        #1;
        check("R10 oe config B", 8'(pad_oe), 8'h1);
        q_exp = 0;
        pat = 8'b1011_0111;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) in_sig = {3'b000, pat[i]};
            #1;
            check("R8 registered output holds", 8'(pad_out[0]), 8'(q_exp));
            check("R9 R10 feedback on disabled cell", 8'(pad_out[1]), 8'(~q_exp & 1'b1));
            @(posedge clk); q_exp = q_exp ^ pat[i];
        end
        @(negedge clk) in_sig = '0;
        #1;
        check("R8 R9 toggle final", 8'(pad_out[0]), 8'(q_exp));

        // Config C shifted in without a load: config B must continue
        cfg_c = '0;
        set_mode(cfg_c, 0, 0, 0, 0);
        set_term(cfg_c, 0, 0, 1);                            // empty mask -> 1
        set_mode(cfg_c, 1, 0, 0, 1);
        set_term(cfg_c, 1, 0, 0); set_lit(cfg_c, 1, 0, 0, 0); // disabled
        set_term(cfg_c, 1, 1, 0);
        shift_cfg(cfg_c);
        #1;
        check("R2 old pattern still active oe", 8'(pad_oe), 8'h1);
        check("R2 old pattern still active out", 8'(pad_out), 8'({~q_exp, q_exp}));
        load_cfg();
        #1;
        check("R2 R10 oe config C", 8'(pad_oe), 8'h2);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk) in_sig = v[3:0];
            #1;
            check("R4 empty enabled term is 1", 8'(pad_out[0]), 8'h1);
            check("R5 disabled terms give 0", 8'(pad_out[1]), 8'h0);
        end

        // Reset mid-run
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        #1;
        check("R3 oe after second reset", 8'(pad_oe), 8'h0);
        check("R3 out after second reset", 8'(pad_out), 8'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule